// File: doc/BRIEF.md
# Real-Mode Linear Address Generator

This block turns a segment-relative memory reference into a flat physical address in the way a real-address-mode processor does. A bank of six 16-bit segment registers, loaded through a simple write port, supplies the segment value. Each request names one of them plus an offset. The segment value is never used to look anything up. Instead it is shifted left by four bit positions and added to the offset, and the result goes straight to memory.

The offset is either 16 bits wide (narrow address size) or 32 bits wide (wide address size). In narrow mode the carry out of bit 19 is kept, so the highest reachable address lies just above 1 MiB. A plain control input, the A20 gate mask, forces bit 20 of the result to zero. This reproduces the wraparound of an old 20-bit bus.

Requests enter on a valid/ready stream and results leave on a second valid/ready stream, through a single register stage. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the following cycle and stays on the output until it is taken with `out_ready`. While an untaken result is waiting, `in_ready` is low, and a request offered during that time is neither accepted nor lost.

Top module: `rm_linear_agen`

## Requirements
- R1: For an accepted request, `out_addr` equals the selected segment value shifted left by 4, plus the effective offset. `out_valid` rises on the clock edge after acceptance.
- R2: In narrow mode (`in_addr32`=0), only `in_offset[15:0]` is used and the carry into bit 20 is kept, so FFFFh:FFFFh gives 10FFEFh. Bits 31..21 are zero.
- R3: When `a20_mask`=1 at acceptance, bit 20 of the result is zero and all other bits are unchanged. FFFFh:FFFFh in narrow mode then gives 0FFEFh. This also applies in wide mode.
- R4: In wide mode (`in_addr32`=1), all 32 offset bits are added and the sum wraps modulo 2^32.
- R5: The segment select code is ES=0, CS=1, SS=2, DS=3, FS=4, GS=5. It is used the same way by `seg_wsel` and `in_sel`.
- R6: After reset, every segment register holds 0000h except CS, which holds FFFFh. `out_valid` is 0.
- R7: When `seg_we`=1, `seg_wdata` is written to the register named by `seg_wsel`. With select codes 6 and 7, a write changes no register, and a request uses a segment value of 0.
- R8: A request accepted on the same edge as a write to its segment uses the value from before the write.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_addr` and `out_valid` hold.
- R10: The address size and the mask are taken at acceptance. Changing them while a result waits does not alter that result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_we | input | 1 | Segment register write enable |
| seg_wsel | input | 3 | Segment register select for the write |
| seg_wdata | input | 16 | Segment value to write |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_sel | input | 3 | Segment register select for the request |
| in_offset | input | 32 | Offset within the segment |
| in_addr32 | input | 1 | 1 = wide (32-bit) offset, 0 = narrow (16-bit) offset |
| a20_mask | input | 1 | 1 = force address bit 20 to zero |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 32 | Linear/physical address |

## Verification
The bench builds the block with its default parameters: 16-bit segments, a 4-bit shift, 32-bit offsets and the mask on bit 20. With these values both corner addresses (10FFEFh and 0FFEFh) and the modulo-2^32 wrap of wide offsets are in reach. Random segment loads, offsets, sizes and mask settings are mixed with directed cases:
- stalls on the output stream;
- a write to a segment on the same edge as a request that uses it;
- writes and requests with the unused select codes.

// File: rtl/rm_agen_pkg.sv
package rm_agen_pkg;
  localparam int NUM_SEG = 6;
  localparam int SEL_W   = 3;

  typedef enum logic [SEL_W-1:0] {
    SEG_ES = 3'd0,
    SEG_CS = 3'd1,
    SEG_SS = 3'd2,
    SEG_DS = 3'd3,
    SEG_FS = 3'd4,
    SEG_GS = 3'd5
  } seg_sel_e;
endpackage

// File: rtl/rm_seg_file.sv
module rm_seg_file
  import rm_agen_pkg::*;
#(
  parameter int          SEG_W    = 16,
  parameter logic [15:0] CS_RESET = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] wsel,
  input  logic [SEG_W-1:0] wdata,
  input  logic [SEL_W-1:0] rsel,
  output logic [SEG_W-1:0] rdata
);
  logic [SEG_W-1:0] seg_q [NUM_SEG];

  function automatic logic [SEG_W-1:0] reset_value(input int idx);
    return (idx == int'(SEG_CS)) ? SEG_W'(CS_RESET) : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEG; i++) seg_q[i] <= reset_value(i);
    end else if (we) begin
      for (int i = 0; i < NUM_SEG; i++)
        if (wsel == SEL_W'(i)) seg_q[i] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (rsel == SEL_W'(i)) rdata = seg_q[i];
  end
endmodule

// File: rtl/rm_addr_calc.sv
module rm_addr_calc #(
  parameter int SEG_W     = 16,
  parameter int SEG_SHIFT = 4,
  parameter int NARROW_W  = 16,
  parameter int OFF_W     = 32,
  parameter int A20_BIT   = 20
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] offset,
  input  logic             wide,
  input  logic             mask,
  output logic [OFF_W-1:0] addr
);
  localparam int BASE_W = SEG_W + SEG_SHIFT;
  localparam logic [OFF_W-1:0] GATE_BIT = OFF_W'(1) << A20_BIT;

  logic [OFF_W-1:0] base;
  logic [OFF_W-1:0] off_eff;
  logic [OFF_W-1:0] sum;

  always_comb begin
    base    = OFF_W'({seg, {SEG_SHIFT{1'b0}}});
    off_eff = wide ? offset : OFF_W'(offset[NARROW_W-1:0]);
    sum     = base + off_eff;
    addr    = mask ? (sum & ~GATE_BIT) : sum;
  end

  if (BASE_W >= OFF_W) begin : g_bad_width
    initial $error("base width must be below offset width");
  end
endmodule

// File: rtl/rm_out_stage.sv
module rm_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/rm_linear_agen.sv
module rm_linear_agen
  import rm_agen_pkg::*;
#(
  parameter int          SEG_W     = 16,
  parameter int          SEG_SHIFT = 4,
  parameter int          NARROW_W  = 16,
  parameter int          OFF_W     = 32,
  parameter int          A20_BIT   = 20,
  parameter logic [15:0] CS_RESET  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seg_we,
  input  logic [2:0]       seg_wsel,
  input  logic [SEG_W-1:0] seg_wdata,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [2:0]       in_sel,
  input  logic [OFF_W-1:0] in_offset,
  input  logic             in_addr32,
  input  logic             a20_mask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OFF_W-1:0] out_addr
);
  logic [SEG_W-1:0] seg_val;
  logic [OFF_W-1:0] addr_c;

  rm_seg_file #(.SEG_W(SEG_W), .CS_RESET(CS_RESET)) u_segs (
    .clk(clk), .rst_n(rst_n), .we(seg_we), .wsel(seg_wsel), .wdata(seg_wdata),
    .rsel(in_sel), .rdata(seg_val)
  );

  rm_addr_calc #(
    .SEG_W(SEG_W), .SEG_SHIFT(SEG_SHIFT), .NARROW_W(NARROW_W),
    .OFF_W(OFF_W), .A20_BIT(A20_BIT)
  ) u_calc (
    .seg(seg_val), .offset(in_offset), .wide(in_addr32), .mask(a20_mask),
    .addr(addr_c)
  );

  rm_out_stage #(.W(OFF_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(addr_c), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_addr)
  );
endmodule

// File: rtl/rm_linear_agen_chk.sv
module rm_linear_agen_chk #(
  parameter int OFF_W   = 32,
  parameter int A20_BIT = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_addr32,
  input logic             a20_mask,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OFF_W-1:0] out_addr
);
  logic accept;
  assign accept = in_valid && in_ready;

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  p_narrow_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_addr32) |=> (out_addr[OFF_W-1:A20_BIT+1] == '0));

  p_gate_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && a20_mask) |=> !out_addr[A20_BIT]);

  p_idle_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));
endmodule

bind rm_linear_agen rm_linear_agen_chk #(.OFF_W(OFF_W), .A20_BIT(A20_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_addr32(in_addr32), .a20_mask(a20_mask), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr)
);

// File: tb/tb_rm_linear_agen.sv
module tb_rm_linear_agen;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        seg_we = 0;
  logic [2:0]  seg_wsel = 0;
  logic [15:0] seg_wdata = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [2:0]  in_sel = 0;
  logic [31:0] in_offset = 0;
  logic        in_addr32 = 0;
  logic        a20_mask = 0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [6];

  always #2 clk = ~clk;

  rm_linear_agen dut (.*);

  function automatic logic [31:0] ref_addr(input logic [15:0] s, input logic [31:0] off,
                                           input logic wide, input logic m);
    logic [31:0] r;
    r = {12'h0, s, 4'h0} + (wide ? off : {16'h0, off[15:0]});
    if (m) r[20] = 1'b0;
    return r;
  endfunction

  function automatic logic [15:0] seg_of(input logic [2:0] s);
    return (s < 3'd6) ? shadow[s] : 16'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_seg(input logic [2:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_we = 1; seg_wsel = s; seg_wdata = v;
    @(negedge clk);
    seg_we = 0;
    if (s < 3'd6) shadow[s] = v;
  endtask

  task automatic issue(input logic [2:0] s, input logic [31:0] off,
                       input logic wide, input logic m);
    @(negedge clk);
    in_valid = 1; in_sel = s; in_offset = off; in_addr32 = wide; a20_mask = m;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic run(input string tag, input logic [2:0] s, input logic [31:0] off,
                     input logic wide, input logic m);
    logic [31:0] e;
    e = ref_addr(seg_of(s), off, wide, m);
    issue(s, off, wide, m);
    check({tag, " valid"}, 32'(out_valid), 32'd1);
    check(tag, out_addr, e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 6; i++) shadow[i] = 16'h0;
    shadow[1] = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    // R6 reset state
    check("R6 out_valid", 32'(out_valid), 32'd0);
    check("R6 in_ready", 32'(in_ready), 32'd1);
    for (int i = 0; i < 6; i++) run("R6 reset seg", 3'(i), 32'h0000_0123, 1'b0, 1'b0);
    // R5 select codes: distinct values per register
    for (int i = 0; i < 6; i++) wr_seg(3'(i), 16'h1000 * 16'(i + 1) + 16'(i));
    for (int i = 0; i < 6; i++) run("R5 select", 3'(i), 32'h10, 1'b0, 1'b0);
    // R2 / R3 corners
    wr_seg(3'd3, 16'hFFFF);
    run("R2 carry corner", 3'd3, 32'h0000_FFFF, 1'b0, 1'b0);
    check("R2 corner value", out_addr, 32'h0010_FFEF);
    run("R3 masked corner", 3'd3, 32'h0000_FFFF, 1'b0, 1'b1);
    check("R3 corner value", out_addr, 32'h0000_FFEF);
    run("R2 upper offset ignored", 3'd3, 32'hABCD_FFFF, 1'b0, 1'b0);
    run("R4 wide wrap", 3'd3, 32'hFFFF_FFFF, 1'b1, 1'b0);
    check("R4 wrap value", out_addr, 32'h000F_FFEF);
    run("R3 wide mask", 3'd3, 32'h0020_0000, 1'b1, 1'b1);
    // R7 unused select codes
    wr_seg(3'd6, 16'h5555);
    wr_seg(3'd7, 16'hAAAA);
    for (int i = 0; i < 6; i++) run("R7 ignored write", 3'(i), 32'h0, 1'b0, 1'b0);
    run("R7 sel7 zero base", 3'd7, 32'h0000_4321, 1'b0, 1'b0);
    run("R7 sel6 zero base", 3'd6, 32'h8000_0001, 1'b1, 1'b0);
    // R8 same-edge write and request
    @(negedge clk);
    seg_we = 1; seg_wsel = 3'd2; seg_wdata = 16'h7777;
    in_valid = 1; in_sel = 3'd2; in_offset = 32'h5; in_addr32 = 0; a20_mask = 0;
    @(negedge clk);
    seg_we = 0; in_valid = 0;
    check("R8 old value used", out_addr, ref_addr(shadow[2], 32'h5, 1'b0, 1'b0));
    shadow[2] = 16'h7777;
    run("R8 new value after", 3'd2, 32'h5, 1'b0, 1'b0);
    // R9 / R10 stall
    @(negedge clk);
    out_ready = 0;
    issue(3'd3, 32'h0000_FFFF, 1'b0, 1'b1);
    check("R9 stalled valid", 32'(out_valid), 32'd1);
    in_valid = 1; in_sel = 3'd1; in_offset = 32'h44; in_addr32 = 1; a20_mask = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R9 in_ready low", 32'(in_ready), 32'd0);
      check("R10 held result", out_addr, 32'h0000_FFEF);
    end
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    check("R9 second after release", out_addr, ref_addr(shadow[1], 32'h44, 1'b1, 1'b0));
    check("R9 second valid", 32'(out_valid), 32'd1);
    // R1 random
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0) wr_seg(3'($urandom_range(0, 5)), 16'($urandom));
      run("R1 random", 3'($urandom_range(0, 5)), $urandom, 1'($urandom), 1'($urandom));
    end
    @(negedge clk);
    check("R1 drained", 32'(out_valid), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule